// File: doc/BRIEF.md
# Serial Flash Controller Request Aggregator

This block collects the status conditions of a serial flash controller into one flag register and gates each condition with its own enable bit. From the gated result it drives five interrupt lines and one DMA request line. The controller core feeds it single-cycle event pulses, two buffer-state levels and an RX-buffer write strobe. Software reaches the flag and enable registers through a one-bit-address register port.

Two conditions are levels that track buffer state: TX space available and RX data present. The other seven are events and are held until software clears them by writing 1. The RX data condition has two separate enables. As an interrupt it follows the not-empty level. As a DMA source it gives one request per write into the RX buffer. The three overflow/underrun events share one interrupt line, and so do the three error events.

Condition bit map, used in both registers: bit 0 TX space, bit 1 TX underrun, bit 2 RX data present, bit 3 RX overflow, bit 4 bus-side buffer overflow, bit 5 command issued during bus access, bit 6 command issued during command, bit 7 bad instruction code, bit 8 transaction done. Enable register bit 9 is the RX DMA enable.

Top module: `qfa_irq_dma_agg`

## Requirements
- R1: A synchronous active-high reset clears all flags, all enables, `reg_rdata` and every request output.
- R2: An event pulse on any of the seven event inputs sets its flag at the next clock edge. The flag then stays set until a register write to address 0 carries a 1 in that bit. Writing 0 to a set flag leaves it set.
- R3: When an event pulse and a write-1 clear of the same flag fall in the same cycle, the flag ends up set.
- R4: Flag bits 0 and 2 are registered copies of `tx_room` and `rx_not_empty`, one cycle late. Register writes to those two bits have no effect.
- R5: A write to address 1 loads `reg_wdata[9:0]` into the enable register, and every enable bit reads back as written.
- R6: `irq_tx_fill` is high one cycle after flag bit 0 and enable bit 0 are both set. `irq_rx_drain` does the same for bit 2.
- R7: `irq_overrun` is the registered OR of flag bits 1, 3 and 4, each gated by its own enable bit.
- R8: `irq_error` is the registered OR of flag bits 5, 6 and 7, each gated by its own enable bit. `irq_done` is the registered AND of flag bit 8 and enable bit 8.
- R9: With enable bit 9 set, each cycle in which `rx_write` is high produces exactly one cycle of `dma_req` on the next cycle. With bit 9 clear there is no `dma_req`, whatever enable bit 2 holds.
- R10: `reg_rdata` shows, one cycle later, the register selected by `reg_addr` (0 = flags, 1 = enables). Flag readback bit 9 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_room | input | 1 | TX buffer can take more data (level) |
| rx_not_empty | input | 1 | RX buffer holds data (level) |
| rx_write | input | 1 | Strobe: one word written into the RX buffer |
| evt_tx_underrun | input | 1 | Event: TX buffer underrun |
| evt_rx_overflow | input | 1 | Event: RX buffer overflow |
| evt_buf_overflow | input | 1 | Event: bus-side buffer overflow |
| evt_cmd_bus_err | input | 1 | Event: command triggered during bus access |
| evt_cmd_cmd_err | input | 1 | Event: command triggered during a command |
| evt_bad_opcode | input | 1 | Event: instruction code error |
| evt_done | input | 1 | Event: transaction finished |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 flags, 1 enables |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 10 | Registered read data |
| irq_tx_fill | output | 1 | TX space interrupt |
| irq_rx_drain | output | 1 | RX data interrupt |
| irq_overrun | output | 1 | Combined overflow/underrun interrupt |
| irq_error | output | 1 | Combined error interrupt |
| irq_done | output | 1 | Transaction done interrupt |
| dma_req | output | 1 | RX drain DMA request pulse |

## Verification
The bench targets the clear that collides with a new event. A design that gives the clear priority would lose the event, and the flag would read 0. It writes 1 to the level flags. A design that treats those bits as sticky would still show the bit, or lose it, once the level falls. It drives back-to-back RX writes with only the DMA enable set, and then with only the RX interrupt enable set. A design that merges the two enables, or stretches or drops pulses, would give the wrong count of `dma_req` cycles. It also pulses events whose enables are clear, and events that belong to the wrong group, to catch a combined interrupt line that takes in the wrong flag.

// File: rtl/qfa_pkg.sv
package qfa_pkg;
  localparam int unsigned NUM_COND = 9;
  localparam int unsigned REG_W    = NUM_COND + 1;
  localparam int unsigned NUM_STKY = 7;

  localparam int unsigned C_TX_FILL  = 0;
  localparam int unsigned C_TX_UNDER = 1;
  localparam int unsigned C_RX_DRAIN = 2;
  localparam int unsigned C_RX_OVF   = 3;
  localparam int unsigned C_BUF_OVF  = 4;
  localparam int unsigned C_CMD_BUS  = 5;
  localparam int unsigned C_CMD_CMD  = 6;
  localparam int unsigned C_OP_ERR   = 7;
  localparam int unsigned C_DONE     = 8;
  localparam int unsigned EN_DMA     = NUM_COND;

  localparam logic [NUM_COND-1:0] OVR_MASK = 9'b0_0001_1010;
  localparam logic [NUM_COND-1:0] ERR_MASK = 9'b0_1110_0000;

  typedef enum logic {ADDR_FLAG = 1'b0, ADDR_EN = 1'b1} reg_sel_e;
endpackage

// File: rtl/qfa_sticky_bank.sv
module qfa_sticky_bank #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)           q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(set_i[i])) |-> flag_o[i]);
    assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(flag_o[i]) && !$past(clr_i[i])) |-> flag_o[i]);
  end
endmodule

// File: rtl/qfa_level_sync.sv
module qfa_level_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] lvl_o
);
  always_ff @(posedge clk) begin
    if (rst) lvl_o <= '0;
    else     lvl_o <= lvl_i;
  end
endmodule

// File: rtl/qfa_enable_reg.sv
module qfa_enable_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (rst)     en_o <= '0;
    else if (we) en_o <= wdata;
  end

  assert_en_load_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(we)) |-> (en_o == $past(wdata)));
endmodule

// File: rtl/qfa_req_out.sv
module qfa_req_out
  import qfa_pkg::*;
#(
  parameter int unsigned N = NUM_COND
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N:0]   en,
  input  logic         rx_write,
  output logic         irq_tx_fill,
  output logic         irq_rx_drain,
  output logic         irq_overrun,
  output logic         irq_error,
  output logic         irq_done,
  output logic         dma_req
);
  logic [N-1:0] gated;
  assign gated = flags & en[N-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx_fill  <= 1'b0;
      irq_rx_drain <= 1'b0;
      irq_overrun  <= 1'b0;
      irq_error    <= 1'b0;
      irq_done     <= 1'b0;
      dma_req      <= 1'b0;
    end else begin
      irq_tx_fill  <= gated[C_TX_FILL];
      irq_rx_drain <= gated[C_RX_DRAIN];
      irq_overrun  <= |(gated & OVR_MASK);
      irq_error    <= |(gated & ERR_MASK);
      irq_done     <= gated[C_DONE];
      dma_req      <= rx_write & en[EN_DMA];
    end
  end
endmodule

// File: rtl/qfa_irq_dma_agg.sv
module qfa_irq_dma_agg
  import qfa_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_room,
  input  logic             rx_not_empty,
  input  logic             rx_write,
  input  logic             evt_tx_underrun,
  input  logic             evt_rx_overflow,
  input  logic             evt_buf_overflow,
  input  logic             evt_cmd_bus_err,
  input  logic             evt_cmd_cmd_err,
  input  logic             evt_bad_opcode,
  input  logic             evt_done,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_tx_fill,
  output logic             irq_rx_drain,
  output logic             irq_overrun,
  output logic             irq_error,
  output logic             irq_done,
  output logic             dma_req
);
  logic                wr_flag, wr_en;
  logic [NUM_STKY-1:0] stk_set, stk_clr, stk_q;
  logic [1:0]          lvl_q;
  logic [NUM_COND-1:0] flags;
  logic [REG_W-1:0]    en_q;

  assign wr_flag = reg_wr && (reg_addr == ADDR_FLAG);
  assign wr_en   = reg_wr && (reg_addr == ADDR_EN);

  assign stk_set = {evt_done, evt_bad_opcode, evt_cmd_cmd_err, evt_cmd_bus_err,
                    evt_buf_overflow, evt_rx_overflow, evt_tx_underrun};
  assign stk_clr = {NUM_STKY{wr_flag}} &
                   {reg_wdata[C_DONE], reg_wdata[C_OP_ERR], reg_wdata[C_CMD_CMD],
                    reg_wdata[C_CMD_BUS], reg_wdata[C_BUF_OVF], reg_wdata[C_RX_OVF],
                    reg_wdata[C_TX_UNDER]};

  qfa_sticky_bank #(.W(NUM_STKY)) u_sticky (
    .clk(clk), .rst(rst), .set_i(stk_set), .clr_i(stk_clr), .flag_o(stk_q));

  qfa_level_sync #(.W(2)) u_level (
    .clk(clk), .rst(rst), .lvl_i({rx_not_empty, tx_room}), .lvl_o(lvl_q));

  qfa_enable_reg #(.W(REG_W)) u_enable (
    .clk(clk), .rst(rst), .we(wr_en), .wdata(reg_wdata), .en_o(en_q));

  assign flags = {stk_q[6], stk_q[5], stk_q[4], stk_q[3], stk_q[2],
                  stk_q[1], lvl_q[1], stk_q[0], lvl_q[0]};

  always_ff @(posedge clk) begin
    if (rst)                     reg_rdata <= '0;
    else if (reg_addr == ADDR_EN) reg_rdata <= en_q;
    else                         reg_rdata <= {1'b0, flags};
  end

  qfa_req_out #(.N(NUM_COND)) u_req (
    .clk(clk), .rst(rst), .flags(flags), .en(en_q), .rx_write(rx_write),
    .irq_tx_fill(irq_tx_fill), .irq_rx_drain(irq_rx_drain),
    .irq_overrun(irq_overrun), .irq_error(irq_error), .irq_done(irq_done),
    .dma_req(dma_req));

  assert_level_follow_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (flags[C_RX_DRAIN] == $past(rx_not_empty)));
  assert_dma_needs_write_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && dma_req) |-> ($past(rx_write) && $past(en_q[EN_DMA])));
  assert_dma_follows_write_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rx_write) && $past(en_q[EN_DMA])) |-> dma_req);
  assert_overrun_gated_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(en_q & REG_W'(OVR_MASK)) == '0)) |-> !irq_overrun);
  assert_error_gated_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(en_q & REG_W'(ERR_MASK)) == '0)) |-> !irq_error);
endmodule

// File: tb/tb_qfa_irq_dma_agg.sv
module tb_qfa_irq_dma_agg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_room = 0, rx_not_empty = 0, rx_write = 0;
  logic evt_tx_underrun = 0, evt_rx_overflow = 0, evt_buf_overflow = 0;
  logic evt_cmd_bus_err = 0, evt_cmd_cmd_err = 0, evt_bad_opcode = 0, evt_done = 0;
  logic reg_wr = 0, reg_addr = 0;
  logic [9:0] reg_wdata = '0;
  logic [9:0] reg_rdata;
  logic irq_tx_fill, irq_rx_drain, irq_overrun, irq_error, irq_done, dma_req;

  qfa_irq_dma_agg dut (.*);

  always #5 clk = ~clk;

  typedef struct {
    int         due;
    bit         is_rd;
    logic [9:0] mask;
    logic [9:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops items whose due cycle has arrived and compares
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [9:0] act;
        act = q[i].is_rd ? reg_rdata
                         : {4'b0, dma_req, irq_done, irq_error, irq_overrun, irq_rx_drain, irq_tx_fill};
        checks++;
        if ((act & q[i].mask) !== (q[i].exp & q[i].mask)) begin
          errors++;
          $display("FAIL %s actual %h expected %h", q[i].req, act & q[i].mask, q[i].exp & q[i].mask);
        end
        q.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(bit rd, logic [9:0] mask, logic [9:0] exp, string req);
    item_t it;
    it.due = cyc + 1; it.is_rd = rd; it.mask = mask; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // irq vector: [0] tx_fill [1] rx_drain [2] overrun [3] error [4] done [5] dma
  task automatic expect_irq(logic [9:0] mask, logic [9:0] exp, string req);
    push(1'b0, mask, exp, req);
    step(1);
  endtask

  task automatic expect_rd(logic a, logic [9:0] exp, string req);
    reg_addr = a;
    push(1'b1, 10'h3FF, exp, req);
    step(1);
  endtask

  task automatic wr(logic a, logic [9:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic pulse(int which);
    case (which)
      1: evt_tx_underrun = 1;
      3: evt_rx_overflow = 1;
      4: evt_buf_overflow = 1;
      5: evt_cmd_bus_err = 1;
      6: evt_cmd_cmd_err = 1;
      7: evt_bad_opcode = 1;
      default: evt_done = 1;
    endcase
    step(1);
    {evt_tx_underrun, evt_rx_overflow, evt_buf_overflow, evt_cmd_bus_err,
     evt_cmd_cmd_err, evt_bad_opcode, evt_done} = '0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 0;
    // R1 reset state
    expect_irq(10'h3F, 10'h00, "R1 outputs after reset");
    expect_rd(1'b0, 10'h000, "R1 flags after reset");
    expect_rd(1'b1, 10'h000, "R1 enables after reset");

    // R5 / R10 enable register
    wr(1'b1, 10'h3FF);
    expect_rd(1'b1, 10'h3FF, "R5 enable readback all set");
    wr(1'b1, 10'h155);
    expect_rd(1'b1, 10'h155, "R5 enable readback pattern");
    wr(1'b1, 10'h000);
    expect_rd(1'b0, 10'h000, "R10 flag readback bit9 zero");

    // R2 sticky event flag
    pulse(8);
    expect_rd(1'b0, 10'h100, "R2 done flag set");
    wr(1'b0, 10'h000);
    expect_rd(1'b0, 10'h100, "R2 write 0 keeps flag");
    wr(1'b0, 10'h100);
    expect_rd(1'b0, 10'h000, "R2 write 1 clears flag");
    pulse(5); pulse(7);
    expect_rd(1'b0, 10'h0A0, "R2 two error flags set");
    wr(1'b0, 10'h020);
    expect_rd(1'b0, 10'h080, "R2 clear only selected bit");
    wr(1'b0, 10'h1FF);

    // R3 set wins over clear
    evt_tx_underrun = 1; reg_wr = 1; reg_addr = 1'b0; reg_wdata = 10'h002;
    step(1);
    evt_tx_underrun = 0; reg_wr = 0; reg_wdata = '0;
    expect_rd(1'b0, 10'h002, "R3 event beats clear");
    wr(1'b0, 10'h002);
    expect_rd(1'b0, 10'h000, "R3 later clear works");

    // R4 level flags
    tx_room = 1; rx_not_empty = 1;
    step(1);
    wr(1'b0, 10'h005);
    expect_rd(1'b0, 10'h005, "R4 level flags ignore write");
    tx_room = 0;
    step(1);
    expect_rd(1'b0, 10'h004, "R4 tx flag follows level");

    // R6 level interrupts gated
    tx_room = 1;
    step(2);
    expect_irq(10'h03, 10'h00, "R6 no irq with enables clear");
    wr(1'b1, 10'h001);
    expect_irq(10'h03, 10'h01, "R6 tx fill irq only");
    wr(1'b1, 10'h004);
    expect_irq(10'h03, 10'h02, "R6 rx drain irq only");
    rx_not_empty = 0; tx_room = 0;
    step(1);
    expect_irq(10'h03, 10'h00, "R6 rx drain irq follows level");

    // R7 overrun group
    wr(1'b1, 10'h01A);
    pulse(3);
    expect_irq(10'h3F, 10'h04, "R7 rx overflow raises overrun");
    wr(1'b0, 10'h008);
    expect_irq(10'h3F, 10'h00, "R7 clear drops overrun");
    pulse(7);
    expect_irq(10'h3F, 10'h00, "R7 error event not in overrun group");
    wr(1'b1, 10'h008);
    pulse(4);
    expect_irq(10'h04, 10'h00, "R7 buf overflow masked by enable");
    wr(1'b1, 10'h010);
    expect_irq(10'h04, 10'h04, "R7 buf overflow enabled");
    wr(1'b0, 10'h1FF);

    // R8 error and done
    wr(1'b1, 10'h1E0);
    pulse(6);
    expect_irq(10'h1C, 10'h08, "R8 command collision raises error");
    pulse(8);
    expect_irq(10'h1C, 10'h18, "R8 done raises done irq");
    wr(1'b0, 10'h040);
    expect_irq(10'h1C, 10'h10, "R8 error drops after clear");
    wr(1'b1, 10'h000);
    expect_irq(10'h1C, 10'h00, "R8 done masked");
    wr(1'b0, 10'h1FF);

    // R9 dma pulses
    wr(1'b1, 10'h200);
    rx_write = 1;
    expect_irq(10'h20, 10'h20, "R9 single write dma");
    rx_write = 0;
    expect_irq(10'h20, 10'h00, "R9 dma is one cycle");
    rx_write = 1;
    expect_irq(10'h20, 10'h20, "R9 back to back first");
    expect_irq(10'h20, 10'h20, "R9 back to back second");
    rx_write = 0;
    expect_irq(10'h20, 10'h00, "R9 back to back end");
    wr(1'b1, 10'h004);
    rx_write = 1;
    expect_irq(10'h20, 10'h00, "R9 no dma with only irq enable");
    rx_write = 0;
    expect_irq(10'h20, 10'h00, "R9 still no dma");

    // R1 reset in mid run clears enables
    wr(1'b1, 10'h3FF);
    pulse(1);
    rst = 1;
    step(1);
    rst = 0;
    expect_rd(1'b1, 10'h000, "R1 reset clears enables");
    expect_rd(1'b0, 10'h000, "R1 reset clears flags");

    step(3);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule